// File: doc/BRIEF.md
# Masked-Write GPIO Port Register Bank

This block is the register file for one bank of general-purpose I/O ports. The bank has four ports of eight pins each. Every port has four writable registers: a pin-ownership (config) register, an output-enable register, an output-value register and an interrupt-enable register. It also has a read-only view of the synchronized pad levels. Software reaches the registers through a plain synchronous bus. A write takes effect at the clock edge on which the write strobe is high. Reads are combinational from the address.

Each writable register also answers at a second address, its masked alias. A write to the alias carries a per-bit mask in the second byte of the write data. Only the pins whose mask bit is set take the new value. Software can therefore change one pin without reading the register first, and two agents that own different pins of a port cannot undo each other's updates. Every register reads back, so a power manager can save the full state and restore it.

The block drives the pad output-enable and output-value vectors. It samples the pad inputs through a two-stage synchronizer. Interrupt detection, pad electrical behaviour and bus bridging are not part of it.

Top module: `gpio_mskbank`

## Requirements
- R1: After reset, every register of every port reads zero, and `pad_oe` and `pad_out` are all zero.
- R2: Register address = type offset + 4 × port. The type offsets are config 0x00, output enable 0x10, output value 0x20, input 0x30 and interrupt enable 0x50.
- R3: A write to a plain register address stores `wdata[7:0]` into that register of that port and leaves every other register unchanged.
- R4: Each writable register has a masked alias at its plain address + 0x800. For every n from 0 to 7, a write to the alias sets register bit n to `wdata[n]` when `wdata[n+8]` is 1, and keeps bit n unchanged when `wdata[n+8]` is 0.
- R5: A read of a masked alias address returns the same value as a read of the plain register.
- R6: A read of the input register of port p returns `pad_in[8p+7:8p]` in bits 7:0, with all higher read bits zero. A pad change shows on the second rising clock edge after it, and not on the first.
- R7: Plain and masked writes to the input register change no register and no pad output.
- R8: Offsets 0x40, 0x60 and 0x70 read as zero. An address with bit 0, 1, 7, 8, 9 or 10 set also reads as zero. Writes to any of these addresses change no state.
- R9: `pad_out[8p+n]` equals output-value bit n of port p. `pad_oe[8p+n]` is 1 only when both config bit n and output-enable bit n of port p are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Byte address of the register access |
| wdata | input | 32 | Write data; bits 15:8 carry the mask on alias writes |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| rdata | output | 32 | Read data for `addr`, combinational |
| pad_in | input | 32 | Pad input levels, 8 per port |
| pad_oe | output | 32 | Pad output enables (config AND output enable) |
| pad_out | output | 32 | Pad output values |

## Verification
A wrong register bit shows at once: on `pad_out` or `pad_oe` in the cycle after the write that set it, and on `rdata` as soon as that address is presented. Mask errors leave a neighbouring pin flipped or stuck. The bench catches these by checking the whole port after each masked write, not only the target pin. A decode fault that aliases an unused or read-only address onto real storage shows up as a changed read-back of the victim register. A synchronizer that is one stage too short or too long is caught by reading the input register on the exact cycle before and after the second edge.

// File: rtl/gpio_mskbank_pkg.sv
package gpio_mskbank_pkg;

   // register type selected by the type field of the address
   typedef enum logic [2:0] {
      RT_CFG = 3'd0,
      RT_OE  = 3'd1,
      RT_OUT = 3'd2,
      RT_IN  = 3'd3,
      RT_STA = 3'd4,
      RT_EN  = 3'd5,
      RT_LVL = 3'd6,
      RT_CLR = 3'd7
   } reg_type_e;

   // number of storage registers per port
   localparam int NUM_KINDS = 4;

   // storage slot -> register type
   function automatic reg_type_e kind_type(input int k);
      case (k)
         0:       return RT_CFG;
         1:       return RT_OE;
         2:       return RT_OUT;
         default: return RT_EN;
      endcase
   endfunction

endpackage

// File: rtl/gpio_mskbank_dec.sv
module gpio_mskbank_dec
   import gpio_mskbank_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int NUM_PORTS = 4,
   localparam int PIDX_W   = $clog2(NUM_PORTS)
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic              alias_sel,
   output reg_type_e         rtype,
   output logic [PIDX_W-1:0] pidx
);
   localparam int TYPE_LSB  = 2 + PIDX_W;
   localparam int TYPE_MSB  = TYPE_LSB + 2;
   localparam int ALIAS_BIT = ADDR_W - 1;

   logic gap_ok;

   generate
      if (ALIAS_BIT <= TYPE_MSB) begin : g_bad_addr
         $error("gpio_mskbank_dec: ADDR_W too small for the type field and the alias bit");
      end
      if (ALIAS_BIT > TYPE_MSB + 1) begin : g_gap
         assign gap_ok = (addr[ALIAS_BIT-1:TYPE_MSB+1] == '0);
      end else begin : g_nogap
         assign gap_ok = 1'b1;
      end
   endgenerate

   assign hit       = gap_ok && (addr[1:0] == 2'b00);
   assign alias_sel = addr[ALIAS_BIT];
   assign rtype     = reg_type_e'(addr[TYPE_MSB:TYPE_LSB]);
   assign pidx      = addr[TYPE_LSB-1:2];

endmodule

// File: rtl/gpio_mskbank_port.sv
module gpio_mskbank_port
   import gpio_mskbank_pkg::*;
#(
   parameter int PORT_W = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_KINDS-1:0]             we,
   input  logic [PORT_W-1:0]                wval,
   input  logic [PORT_W-1:0]                wmask,
   output logic [NUM_KINDS-1:0][PORT_W-1:0] q
);

   generate
      for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q[k] <= '0;
            end else if (we[k]) begin
               q[k] <= (q[k] & ~wmask) | (wval & wmask);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/gpio_mskbank_sync.sv
module gpio_mskbank_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_mskbank_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain[s] <= '0;
            end else if (s == 0) begin
               chain[s] <= d;
            end else begin
               chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_mskbank.sv
module gpio_mskbank
   import gpio_mskbank_pkg::*;
#(
   parameter int NUM_PORTS   = 4,
   parameter int PORT_W      = 8,
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2,
   localparam int PINS       = NUM_PORTS * PORT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_en,
   output logic [DATA_W-1:0] rdata,
   input  logic [PINS-1:0]   pad_in,
   output logic [PINS-1:0]   pad_oe,
   output logic [PINS-1:0]   pad_out
);
   localparam int PIDX_W = $clog2(NUM_PORTS);

   generate
      if (NUM_PORTS < 2 || (1 << PIDX_W) != NUM_PORTS) begin : g_bad_ports
         $error("gpio_mskbank: NUM_PORTS must be a power of two, at least 2");
      end
      if (DATA_W < 2 * PORT_W) begin : g_bad_data
         $error("gpio_mskbank: DATA_W must hold a value byte and a mask byte");
      end
   endgenerate

   logic              hit;
   logic              alias_sel;
   reg_type_e         rtype;
   logic [PIDX_W-1:0] pidx;

   gpio_mskbank_dec #(
      .ADDR_W   (ADDR_W),
      .NUM_PORTS(NUM_PORTS)
   ) dec_i (
      .addr     (addr),
      .hit      (hit),
      .alias_sel(alias_sel),
      .rtype    (rtype),
      .pidx     (pidx)
   );

   logic [PORT_W-1:0] wval;
   logic [PORT_W-1:0] wmask;
   logic              unused_wdata_hi;

   assign wval  = wdata[PORT_W-1:0];
   assign wmask = alias_sel ? wdata[2*PORT_W-1:PORT_W] : '1;

   generate
      if (DATA_W > 2 * PORT_W) begin : g_hi
         assign unused_wdata_hi = ^wdata[DATA_W-1:2*PORT_W];
      end else begin : g_nohi
         assign unused_wdata_hi = 1'b0;
      end
   endgenerate

   logic [NUM_PORTS-1:0][NUM_KINDS-1:0][PORT_W-1:0] regs;
   logic [PINS-1:0]                                 cfg_all;
   logic [PINS-1:0]                                 in_sync;

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         logic [NUM_KINDS-1:0] we;
         for (genvar k = 0; k < NUM_KINDS; k++) begin : g_we
            assign we[k] = wr_en && hit && (pidx == PIDX_W'(p)) && (rtype == kind_type(k));
         end

         gpio_mskbank_port #(
            .PORT_W(PORT_W)
         ) port_i (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (we),
            .wval (wval),
            .wmask(wmask),
            .q    (regs[p])
         );

         assign cfg_all[p*PORT_W +: PORT_W] = regs[p][0];
         assign pad_oe [p*PORT_W +: PORT_W] = regs[p][0] & regs[p][1];
         assign pad_out[p*PORT_W +: PORT_W] = regs[p][2];
      end
   endgenerate

   gpio_mskbank_sync #(
      .WIDTH (PINS),
      .STAGES(SYNC_STAGES)
   ) sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pad_in),
      .q    (in_sync)
   );

   logic [PORT_W-1:0] rsel;

   always_comb begin
      rsel = '0;
      if (hit) begin
         case (rtype)
            RT_CFG:  rsel = regs[pidx][0];
            RT_OE:   rsel = regs[pidx][1];
            RT_OUT:  rsel = regs[pidx][2];
            RT_EN:   rsel = regs[pidx][3];
            RT_IN:   rsel = in_sync[pidx*PORT_W +: PORT_W];
            default: rsel = '0;
         endcase
      end
   end

   assign rdata = {{(DATA_W-PORT_W){1'b0}}, rsel};

endmodule

// File: rtl/gpio_mskbank_chk.sv
module gpio_mskbank_chk #(
   parameter int NUM_PORTS = 4,
   parameter int PORT_W    = 8,
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   localparam int PINS     = NUM_PORTS * PORT_W,
   localparam int TYPE_LSB = 2 + $clog2(NUM_PORTS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic [PORT_W-1:0] wmask,
   input logic              wr_en,
   input logic [DATA_W-1:0] rdata,
   input logic [PORT_W-1:0] pad_in0,
   input logic [PINS-1:0]   pad_oe,
   input logic [PINS-1:0]   pad_out,
   input logic [PINS-1:0]   cfg_all
);
   localparam logic [ADDR_W-1:0] IN0_ADDR = ADDR_W'(3) << TYPE_LSB;

   logic [1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since_rst <= 2'd0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R9
   oe_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & ~cfg_all) == '0);

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(pad_oe) && $stable(pad_out)));

   // R7
   in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr[TYPE_LSB+2:TYPE_LSB] == 3'd3) |=> ($stable(pad_oe) && $stable(pad_out)));

   // R4
   zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr[ADDR_W-1] && wmask == '0) |=> ($stable(pad_oe) && $stable(pad_out)));

   // R6
   sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3 && addr == IN0_ADDR) |-> (rdata[PORT_W-1:0] == $past(pad_in0, 2)));

   // R6
   rdata_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[DATA_W-1:PORT_W] == '0);

endmodule

bind gpio_mskbank gpio_mskbank_chk #(
   .NUM_PORTS(NUM_PORTS),
   .PORT_W   (PORT_W),
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W)
) chk_i (
   .clk    (clk),
   .rst_n  (rst_n),
   .addr   (addr),
   .wmask  (wdata[2*PORT_W-1:PORT_W]),
   .wr_en  (wr_en),
   .rdata  (rdata),
   .pad_in0(pad_in[PORT_W-1:0]),
   .pad_oe (pad_oe),
   .pad_out(pad_out),
   .cfg_all(cfg_all)
);

// File: tb/gpio_mskbank_tb.sv
module gpio_mskbank_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic        wr_en = 1'b0;
   logic [31:0] rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_oe;
   logic [31:0] pad_out;

   int  errors = 0;
   int  checks = 0;
   bit  done = 1'b0;

   // expected contents: [port][slot], slot 0 cfg, 1 oe, 2 out, 3 int enable
   logic [7:0] m [4][4];

   always #5 clk = ~clk;

   gpio_mskbank dut_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (addr),
      .wdata  (wdata),
      .wr_en  (wr_en),
      .rdata  (rdata),
      .pad_in (pad_in),
      .pad_oe (pad_oe),
      .pad_out(pad_out)
   );

   function automatic logic [11:0] raddr(input int k, input int p);
      logic [11:0] base;
      case (k)
         0:       base = 12'h000;
         1:       base = 12'h010;
         2:       base = 12'h020;
         default: base = 12'h050;
      endcase
      return base + 12'(4 * p);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      addr  = a;
      wdata = d;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   function automatic logic [31:0] exp_oe();
      logic [31:0] v;
      for (int p = 0; p < 4; p++) v[p*8 +: 8] = m[p][0] & m[p][1];
      return v;
   endfunction

   function automatic logic [31:0] exp_out();
      logic [31:0] v;
      for (int p = 0; p < 4; p++) v[p*8 +: 8] = m[p][2];
      return v;
   endfunction

   task automatic check_all(input string req);
      logic [31:0] d;
      for (int p = 0; p < 4; p++) begin
         for (int k = 0; k < 4; k++) begin
            rd(raddr(k, p), d);
            chk(req, d, {24'h0, m[p][k]});
         end
      end
      chk({req, " pads R9"}, pad_out, exp_out());
      chk({req, " pads R9"}, pad_oe, exp_oe());
   endtask

   // R1: reset state
   task automatic t_reset();
      for (int p = 0; p < 4; p++) for (int k = 0; k < 4; k++) m[p][k] = 8'h00;
      check_all("R1 reset");
   endtask

   // R2, R3, R9: plain writes to every register of every port
   task automatic t_plain();
      for (int p = 0; p < 4; p++) begin
         for (int k = 0; k < 4; k++) begin
            logic [7:0] v;
            v = 8'(8'h3C ^ (p * 37) ^ (k * 90));
            wr(raddr(k, p), {16'hFFFF, 8'hEE, v});
            m[p][k] = v;
         end
      end
      check_all("R2 R3 plain");
   endtask

   // R4, R5, R9: masked alias writes
   task automatic t_masked();
      logic [31:0] d;
      // set and clear a mix of pins in output value of port 2
      wr(raddr(2, 2) | 12'h800, {16'h0, 8'h0F, 8'hA5});
      m[2][2] = (m[2][2] & 8'hF0) | 8'h05;
      check_all("R4 mask low nibble");
      // single-pin update on config of port 1 (affects pad_oe)
      wr(raddr(0, 1) | 12'h800, {16'h0, 8'h10, 8'h00});
      m[1][0] = m[1][0] & 8'hEF;
      wr(raddr(0, 1) | 12'h800, {16'h0, 8'h01, 8'hFF});
      m[1][0] = m[1][0] | 8'h01;
      check_all("R4 single pin");
      // zero mask changes nothing
      wr(raddr(1, 3) | 12'h800, {16'h0, 8'h00, 8'h5A});
      check_all("R4 zero mask");
      // full mask acts as plain write, on interrupt enable of port 0
      wr(raddr(3, 0) | 12'h800, {16'h0, 8'hFF, 8'hC3});
      m[0][3] = 8'hC3;
      check_all("R4 full mask");
      // alias reads return plain values
      for (int p = 0; p < 4; p++) begin
         rd(raddr(2, p) | 12'h800, d);
         chk("R5 alias read", d, {24'h0, m[p][2]});
      end
      rd(raddr(0, 1) | 12'h800, d);
      chk("R5 alias read cfg", d, {24'h0, m[1][0]});
   endtask

   // R6: input path, latency and upper bits
   task automatic t_input();
      logic [31:0] d;
      logic [31:0] prev;
      prev = pad_in;
      @(negedge clk);
      pad_in = 32'h8E_41_D2_07;
      @(negedge clk);
      for (int p = 0; p < 4; p++) begin
         rd(12'h030 + 12'(4 * p), d);
         chk("R6 first edge old", d, {24'h0, prev[p*8 +: 8]});
      end
      @(negedge clk);
      for (int p = 0; p < 4; p++) begin
         rd(12'h030 + 12'(4 * p), d);
         chk("R6 second edge new", d, {24'h0, pad_in[p*8 +: 8]});
      end
      @(negedge clk);
      pad_in = 32'h17_FF_00_B9;
      @(negedge clk);
      @(negedge clk);
      rd(12'h038, d);
      chk("R6 port 2 pattern", d, 32'h0000_00FF);
      rd(12'h830, d);
      chk("R6 alias of input", d, 32'h0000_00B9);
   endtask

   // R7: writes to the input register
   task automatic t_in_write();
      logic [31:0] d;
      wr(12'h034, 32'hFFFF_FFFF);
      wr(12'h834, 32'h0000_FF00);
      rd(12'h034, d);
      chk("R7 input after write", d, {24'h0, pad_in[15:8]});
      check_all("R7 no register change");
   endtask

   // R8: undecoded and unimplemented addresses
   task automatic t_undecoded();
      logic [31:0] d;
      logic [11:0] bad [8];
      bad[0] = 12'h040; bad[1] = 12'h064; bad[2] = 12'h07C; bad[3] = 12'h0A0;
      bad[4] = 12'h120; bad[5] = 12'h421; bad[6] = 12'h022; bad[7] = 12'h840;
      for (int i = 0; i < 8; i++) wr(bad[i], 32'h0000_FF77);
      for (int i = 0; i < 8; i++) begin
         rd(bad[i], d);
         chk("R8 reads zero", d, 32'h0);
      end
      check_all("R8 no register change");
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_plain();
      t_masked();
      t_input();
      t_in_write();
      t_undecoded();
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         finish_run();
      end
   end

endmodule